// File: doc/BRIEF.md
# Single-Outstanding Interrupt Request Concentrator

The concentrator collects 64 level-sensitive interrupt lines and passes at most one of them to a processor as a request index with a valid flag. Lines 0 to 31 come from an expansion bus. They are grouped four to a group, and each group of four shares one enable. Lines 32 to 63 come from on-board devices, and each of these lines has its own enable. The request stays in place until software retires it through a clear register, or withdraws it by disabling its mapping register. The block then scans again for the next line that is both pending and enabled.

A two-state controller drives the block. In IDLE there is no outstanding request. The transition IDLE->HELD ("select") fires when some line is pending and enabled, and it captures the lowest such line. In HELD the request is outstanding. The transition HELD->HELD ("preempt") replaces the index when an enabled expansion line rises. The transition HELD->IDLE ("retire") fires on a matching clear write or on a withdrawing mapping write. Any other cycle leaves the state as it is ("hold").

Software sees a 32-bit register port with a 16-bit byte address. Data lives in the upper word of each 8-byte slot, so address bit 2 must be 1.

| Register | Address of the data word | Count |
|---|---|---|
| Expansion mapping register g | 0x0C04 + 8*g | 8 |
| On-board mapping register k | 0x1004 + 8*k | 32 |
| Expansion clear register g | 0x1404 + 32*g | 8 |
| On-board clear register k | 0x1804 + 8*k | 32 |

Top module: `irq_funnel`

## Requirements
- R1: After reset req_valid is 0. Every enable is 0. Expansion mapping register g reads 0x7C0 | (g<<2), and on-board mapping register k reads 0x7E0 + k.
- R2: A mapping-register write changes only bit 31, which is the enable. Bits 30:0 are read-only. Reads of a slot's lower word (address bit 2 = 0) return 0. Reads of unmapped addresses return 0, and writes to them change nothing.
- R3: Line i (i < 32) is enabled by expansion mapping register i/4. Line 32+k is enabled by on-board mapping register k.
- R4: In IDLE, the edge that samples a pending enabled line moves the block to HELD. The index captured is the lowest such line, so expansion lines win over on-board lines.
- R5: A held request keeps its index. Deasserting its input does not withdraw it.
- R6: In HELD, a rising enabled expansion line replaces the index at the edge that samples it; if several rise, the lowest wins. A rising on-board line in HELD changes nothing.
- R7: A write to expansion clear register g retires the request only if the held index is below 32 and index/4 = g. The block then goes to IDLE, and it scans again at the next edge.
- R8: A write to on-board clear register k retires the request only if the held index equals 32+k.
- R9: Writing 0 to bit 31 of the mapping register that covers the held line withdraws the request (HELD->IDLE).
- R10: A line whose enable is 0 is never selected, and the block never holds a disabled line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 64 | Level interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| req_valid | output | 1 | A request is outstanding |
| req_index | output | 6 | Index of the outstanding line (0 while idle) |

## Verification
Every result has a fixed due time. A register read is due in the same cycle as the address. Selection and preemption appear just after the first edge that samples the input. A retire or withdraw drops req_valid just after the edge of the write, and the next selection appears one edge after that. The bench drives and samples one time unit after each rising edge, so it always reads a value that exactly one edge has produced. Around each retire it checks both the cleared cycle and the reselected cycle. The line sweep visits all 64 lines, and the priority sweep pairs each low line with a high line.

// File: rtl/irq_funnel_pkg.sv
package irq_funnel_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HELD = 1'b1
    } fun_state_t;

    localparam logic [15:0] MAPX_BASE = 16'h0C00;
    localparam logic [15:0] MAPS_BASE = 16'h1000;
    localparam logic [15:0] CLRX_BASE = 16'h1400;
    localparam logic [15:0] CLRS_BASE = 16'h1800;
    localparam logic [30:0] TAG_X     = 31'h7C0;
    localparam logic [30:0] TAG_S     = 31'h7E0;
endpackage

// File: rtl/irq_funnel_pick.sv
module irq_funnel_pick #(
    parameter int W  = 64,
    parameter int PW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          hit,
    output logic [PW-1:0] pos
);
    always_comb begin
        pos = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) pos = PW'(i);
        end
        hit = |vec;
    end
endmodule

// File: rtl/irq_funnel_regs.sv
module irq_funnel_regs
    import irq_funnel_pkg::*;
#(
    parameter int N_GROUPS = 8,
    parameter int N_SOLO   = 32,
    localparam int GW = $clog2(N_GROUPS),
    localparam int SW = $clog2(N_SOLO)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [15:0]         addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    output logic [N_GROUPS-1:0] en_x,
    output logic [N_SOLO-1:0]   en_s,
    output logic                mapx_wr,
    output logic [GW-1:0]       mapx_sel,
    output logic                maps_wr,
    output logic [SW-1:0]       maps_sel,
    output logic                clrx_wr,
    output logic [GW-1:0]       clrx_sel,
    output logic                clrs_wr,
    output logic [SW-1:0]       clrs_sel,
    output logic                wbit
);
    logic hi_word, in_mapx, in_maps, in_clrx, in_clrs;

    always_comb begin
        hi_word  = addr[2];
        in_mapx  = (addr[15:6] == MAPX_BASE[15:6]);
        in_maps  = (addr[15:8] == MAPS_BASE[15:8]);
        in_clrx  = (addr[15:8] == CLRX_BASE[15:8]);
        in_clrs  = (addr[15:8] == CLRS_BASE[15:8]);
        mapx_sel = addr[3 +: GW];
        maps_sel = addr[3 +: SW];
        clrx_sel = addr[5 +: GW];
        clrs_sel = addr[3 +: SW];
        mapx_wr  = wr && hi_word && in_mapx;
        maps_wr  = wr && hi_word && in_maps;
        clrx_wr  = wr && hi_word && in_clrx;
        clrs_wr  = wr && hi_word && in_clrs;
        wbit     = wdata[31];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_x <= '0;
            en_s <= '0;
        end else begin
            if (mapx_wr) en_x[mapx_sel] <= wbit;
            if (maps_wr) en_s[maps_sel] <= wbit;
        end
    end

    always_comb begin
        rdata = '0;
        if (hi_word && in_mapx)
            rdata = {en_x[mapx_sel], TAG_X | (31'(mapx_sel) << 2)};
        else if (hi_word && in_maps)
            rdata = {en_s[maps_sel], TAG_S + 31'(maps_sel)};
    end

    // R2: a mapping write lands in exactly the addressed enable
    p_map_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mapx_wr |=> en_x[$past(mapx_sel)] == $past(wbit));
    p_solo_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        maps_wr |=> en_s[$past(maps_sel)] == $past(wbit));
endmodule

// File: rtl/irq_funnel.sv
module irq_funnel
    import irq_funnel_pkg::*;
#(
    parameter int N_GROUPS = 8,
    parameter int GROUP_W  = 4,
    parameter int N_SOLO   = 32,
    localparam int N_EXP   = N_GROUPS * GROUP_W,
    localparam int N_LINES = N_EXP + N_SOLO,
    localparam int IDX_W   = $clog2(N_LINES),
    localparam int XW      = $clog2(N_EXP),
    localparam int GW      = $clog2(N_GROUPS),
    localparam int SW      = $clog2(N_SOLO)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               reg_wr,
    input  logic [15:0]        reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               req_valid,
    output logic [IDX_W-1:0]   req_index
);
    fun_state_t state, nstate;
    logic [IDX_W-1:0]   cur_idx, nidx;
    logic [N_LINES-1:0] pend, en_line, cand;
    logic [N_EXP-1:0]   rise;
    logic [N_GROUPS-1:0] en_x;
    logic [N_SOLO-1:0]  en_s;
    logic mapx_wr, maps_wr, clrx_wr, clrs_wr, wbit;
    logic [GW-1:0] mapx_sel, clrx_sel;
    logic [SW-1:0] maps_sel, clrs_sel;
    logic cand_hit, rise_hit, retire, map_busy, held_is_x;
    logic [IDX_W-1:0] cand_pos;
    logic [XW-1:0]    rise_pos;
    logic [GW-1:0]    held_grp;
    logic [SW-1:0]    held_solo;

    irq_funnel_regs #(.N_GROUPS(N_GROUPS), .N_SOLO(N_SOLO)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .en_x(en_x), .en_s(en_s),
        .mapx_wr(mapx_wr), .mapx_sel(mapx_sel), .maps_wr(maps_wr),
        .maps_sel(maps_sel), .clrx_wr(clrx_wr), .clrx_sel(clrx_sel),
        .clrs_wr(clrs_wr), .clrs_sel(clrs_sel), .wbit(wbit)
    );

    for (genvar i = 0; i < N_EXP; i++) begin : g_xen
        assign en_line[i] = en_x[i / GROUP_W];
    end
    for (genvar k = 0; k < N_SOLO; k++) begin : g_sen
        assign en_line[N_EXP + k] = en_s[k];
    end

    assign cand = irq_in & en_line;
    assign rise = irq_in[N_EXP-1:0] & ~pend[N_EXP-1:0] & en_line[N_EXP-1:0];

    irq_funnel_pick #(.W(N_LINES)) u_pick_all (.vec(cand), .hit(cand_hit), .pos(cand_pos));
    irq_funnel_pick #(.W(N_EXP))   u_pick_rise (.vec(rise), .hit(rise_hit), .pos(rise_pos));

    always_comb begin
        held_is_x = cur_idx < IDX_W'(N_EXP);
        held_grp  = GW'(cur_idx / IDX_W'(GROUP_W));
        held_solo = SW'(cur_idx - IDX_W'(N_EXP));
        map_busy  = mapx_wr || maps_wr;
        retire    = (clrx_wr && held_is_x && held_grp == clrx_sel)
                 || (clrs_wr && !held_is_x && held_solo == clrs_sel)
                 || (mapx_wr && !wbit && held_is_x && held_grp == mapx_sel)
                 || (maps_wr && !wbit && !held_is_x && held_solo == maps_sel);
    end

    always_comb begin
        nstate = state;
        nidx   = cur_idx;
        unique case (state)
            ST_IDLE: if (cand_hit && !map_busy) begin
                nstate = ST_HELD;
                nidx   = cand_pos;
            end
            ST_HELD: if (retire) begin
                nstate = ST_IDLE;
            end else if (rise_hit && !map_busy) begin
                nidx = IDX_W'(rise_pos);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_idx <= '0;
            pend    <= '0;
        end else begin
            state   <= nstate;
            cur_idx <= nidx;
            pend    <= irq_in;
        end
    end

    always_comb begin
        req_valid = (state == ST_HELD);
        req_index = (state == ST_HELD) ? cur_idx : '0;
    end

    p_held_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> en_line[req_index]);
    p_retire_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && retire) |=> !req_valid);
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !retire && !rise_hit) |=> (req_valid && $stable(req_index)));
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !cand_hit) |=> !req_valid);
endmodule

// File: tb/tb_irq_funnel.sv
module tb_irq_funnel;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid;
    logic [5:0]  req_index;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    irq_funnel dut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_index(req_index));

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic rd(input string tag, input logic [15:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
        reg_addr = '0;
    endtask

    function automatic logic [15:0] map_addr(input int line);
        return (line < 32) ? 16'(16'h0C04 + 8 * (line / 4)) : 16'(16'h1004 + 8 * (line - 32));
    endfunction

    function automatic logic [15:0] clr_addr(input int line);
        return (line < 32) ? 16'(16'h1404 + 32 * (line / 4)) : 16'(16'h1804 + 8 * (line - 32));
    endfunction

    task automatic req_is(input string tag, input bit v, input int idx);
        check({tag, " valid"}, 32'(req_valid), 32'(v));
        check({tag, " index"}, 32'(req_index), v ? 32'(idx) : 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        req_is("R1 in reset", 0, 0);
        rst_n = 1'b1;
        step();
        req_is("R1 after reset", 0, 0);
        for (int g = 0; g < 8; g++) rd("R1 xmap reset", 16'(16'h0C04 + 8 * g), 32'h7C0 | 32'(g << 2));
        for (int k = 0; k < 32; k++) rd("R1 smap reset", 16'(16'h1004 + 8 * k), 32'h7E0 + 32'(k));
        rd("R2 lower word xmap", 16'h0C00, 32'h0);
        rd("R2 lower word smap", 16'h1008, 32'h0);

        // R10: lines with enables clear stay unselected
        irq_in = 64'hFFFF_FFFF_FFFF_FFFF;
        step(); step();
        req_is("R10 all disabled", 0, 0);
        irq_in = '0;
        step();

        // R2: only bit 31 writable; unmapped ignored
        wr(16'h0C04, 32'hFFFF_FFFF);
        rd("R2 xmap enable only", 16'h0C04, 32'h8000_07C0);
        wr(16'h0C04, 32'h0);
        rd("R2 xmap disable", 16'h0C04, 32'h7C0);
        wr(16'h1014, 32'h1234_5678);
        rd("R2 smap ro field", 16'h1014, 32'h7E2);
        wr(16'h2000, 32'hFFFF_FFFF);
        rd("R2 unmapped read", 16'h2000, 32'h0);
        wr(16'h0C00, 32'hFFFF_FFFF);
        rd("R2 lower word write ignored", 16'h0C04, 32'h7C0);
        irq_in[0] = 1'b1;
        step();
        req_is("R2 unmapped write no enable", 0, 0);
        irq_in = '0;
        step();

        // Sweep every line: select, hold, wrong clear, right clear
        for (int ln = 0; ln < 64; ln++) begin
            int other;
            wr(map_addr(ln), 32'h8000_0000);
            irq_in[ln] = 1'b1;
            step();
            req_is("R3 R4 sweep select", 1, ln);
            irq_in = '0;
            step();
            req_is("R5 sweep deassert kept", 1, ln);
            other = (ln < 32) ? ((ln + 4) % 32) : (32 + ((ln - 32 + 1) % 32));
            wr(clr_addr(other), 32'h0);
            req_is(ln < 32 ? "R7 wrong group clear" : "R8 wrong line clear", 1, ln);
            wr(clr_addr(ln), 32'h0);
            req_is(ln < 32 ? "R7 clear retires" : "R8 clear retires", 0, 0);
            step();
            req_is("R7 R8 stays idle", 0, 0);
            wr(map_addr(ln), 32'h0);
        end

        // R3: a group enable covers all four lines of the group only
        wr(16'h0C14, 32'h8000_0000);
        irq_in[12] = 1'b1;
        step();
        req_is("R3 neighbour group disabled", 0, 0);
        irq_in[11] = 1'b1;
        step();
        req_is("R3 group line 11", 1, 11);
        irq_in = '0;
        wr(16'h1444, 32'h0);
        wr(16'h0C14, 32'h0);

        // Enable everything for priority sweeps
        for (int g = 0; g < 8; g++) wr(16'(16'h0C04 + 8 * g), 32'h8000_0000);
        for (int k = 0; k < 32; k++) wr(16'(16'h1004 + 8 * k), 32'h8000_0000);
        for (int p = 0; p < 32; p++) begin
            irq_in = (64'd1 << p) | (64'd1 << (63 - p));
            step();
            req_is("R4 expansion before onboard", 1, p);
            irq_in = '0;
            wr(clr_addr(p), 32'h0);
            req_is("R7 priority clear", 0, 0);
        end
        for (int p = 0; p < 31; p++) begin
            irq_in = (64'd1 << (32 + p)) | (64'd1 << 63);
            step();
            req_is("R4 lowest onboard", 1, 32 + p);
            irq_in = '0;
            wr(clr_addr(32 + p), 32'h0);
            req_is("R8 priority clear", 0, 0);
        end

        // R6: preemption by expansion lines only
        irq_in[40] = 1'b1;
        step();
        req_is("R6 hold onboard 40", 1, 40);
        irq_in[5] = 1'b1;
        step();
        req_is("R6 expansion preempts", 1, 5);
        irq_in[33] = 1'b1;
        step();
        req_is("R6 onboard rise ignored", 1, 5);
        wr(16'h1424, 32'h0);
        req_is("R7 retire preempted", 0, 0);
        step();
        req_is("R7 reselect lowest", 1, 5);
        irq_in[5] = 1'b0;
        wr(16'h1424, 32'h0);
        req_is("R7 retire again", 0, 0);
        step();
        req_is("R4 reselect onboard", 1, 33);
        irq_in = '0;
        wr(16'h180C, 32'h0);
        req_is("R8 retire 33", 0, 0);

        // R9: withdraw through mapping enable
        irq_in[45] = 1'b1;
        step();
        req_is("R9 hold 45", 1, 45);
        wr(16'h1004 + 16'd8 * 16'd13, 32'h0);
        req_is("R9 onboard withdraw", 0, 0);
        step();
        req_is("R10 disabled stays idle", 0, 0);
        irq_in[14] = 1'b1;
        step();
        req_is("R9 hold 14", 1, 14);
        wr(16'h0C1C, 32'h0);
        req_is("R9 group withdraw", 0, 0);
        step();
        req_is("R10 group disabled idle", 0, 0);
        irq_in = '0;
        step();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule